// File: doc/BRIEF.md
# Interrupt Acceptance Entry Sequencer

This block sits between a CPU core's interrupt sources and its instruction fetch stage. It watches four kinds of request: one non-maskable line, a small set of external request lines that each carry a fixed level, an encoded level input in which zero means "no request", and a peripheral request that comes with its own level. Each kind of request must stay asserted for a fixed number of cycles, set per kind, before the block treats it as decided. A decided request then takes part in priority arbitration and in the comparison against the status-register mask level.

A request is taken only at an instruction boundary, and only when the block bit that results from the finishing instruction is clear. When a request is taken, the block emits a one-cycle save pulse that tells the core to store its status and program counter. The status update written with that pulse sets the block bit and loads the new mask level. Exactly five cycles later, a one-cycle redirect pulse starts the fetch at the handler, and a vector code names the source that won. No new request is taken while this entry sequence is running.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `save_sr_pc` and `fetch_redirect` are low, and `vector_code` and `save_imask` are zero.
- R2: A request must be held continuously before it is decided. The hold is 3 cycles for the non-maskable line, 5 for an external line, 4 for the encoded level and 4 for the peripheral request. If `instr_done` stays high and the block bit stays clear, `save_sr_pc` goes high after the clock edge that follows the last cycle of the hold: it is first seen after latency+1 edges, counted from the first edge that samples the request.
- R3: A request is taken only in a cycle where `instr_done` is high. A decided request waits while `instr_done` stays low.
- R4: At the boundary, the effective block bit is 1 if `instr_sets_bl` is high. Otherwise it is 0 if `instr_clears_bl` is high. Otherwise it equals `sr_bl`. A request is taken only when the effective block bit is 0, and this applies to the non-maskable line as well.
- R5: A maskable request is taken only when its level is strictly greater than `sr_imask`. The non-maskable line ignores the mask.
- R6: Among decided requests, the non-maskable line wins first. After it, the highest level wins. On equal levels the order is external line, then encoded level, then peripheral. External line k carries level 15-2k, so line 0 is the highest.
- R7: `save_sr_pc` is a one-cycle pulse. While it is high, `save_imask` holds the taken level, which is 15 for the non-maskable line. The status update that goes with the pulse sets the block bit to 1.
- R8: `fetch_redirect` is a one-cycle pulse that comes exactly 5 cycles after `save_sr_pc`.
- R9: While `fetch_redirect` is high, `vector_code` is 0x10 for the non-maskable line, 0x20+k for external line k, 0x40+level for the encoded level and 0x80+level for the peripheral request.
- R10: No request is taken from the `save_sr_pc` cycle through the `fetch_redirect` cycle. If a request is still held with the boundary open, the next `save_sr_pc` comes 2 cycles after `fetch_redirect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | The executing instruction completes this cycle |
| instr_clears_bl | input | 1 | The completing instruction writes the block bit to 0 |
| instr_sets_bl | input | 1 | The completing instruction (or an exception) sets the block bit |
| sr_bl | input | 1 | Current status block bit |
| sr_imask | input | 4 | Current status mask level |
| nmi | input | 1 | Non-maskable request |
| irq | input | 4 | External request lines, line k at level 15-2k |
| irl_level | input | 4 | Encoded request level, 0 = none |
| periph_req | input | 1 | Peripheral request |
| periph_level | input | 4 | Peripheral request level |
| save_sr_pc | output | 1 | One-cycle pulse: save status and PC, set block bit, load mask |
| save_imask | output | 4 | New mask level written with the save |
| fetch_redirect | output | 1 | One-cycle pulse: start fetching the handler |
| vector_code | output | 8 | Code naming the source that was taken |

## Verification
Two things can land in the same cycle. One is the end of the decision hold for several sources at once, where arbitration must settle the winner. The other is the boundary at which a held request becomes eligible again just as the entry sequence finishes. The bench holds `instr_done` low while sources with different hold latencies all become decided, then opens the boundary in a single cycle. It judges the winner by the vector code and the saved level. The bench also keeps the non-maskable line held through an entire entry sequence and checks that the second save pulse lands exactly two cycles after the redirect and never earlier.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    SRC_NMI = 2'd0,
    SRC_EXT = 2'd1,
    SRC_ENC = 2'd2,
    SRC_PER = 2'd3
  } src_e;

  typedef struct packed {
    logic       valid;
    src_e       src;
    logic [3:0] level;
    logic [3:0] line;
  } win_t;

  // Fixed level of external request line k
  function automatic logic [3:0] ext_line_level(input int unsigned k);
    return 4'(15 - 2 * k);
  endfunction

  // Vector code for a taken source
  function automatic logic [7:0] vec_of(input src_e src, input logic [3:0] level,
                                        input logic [3:0] line);
    case (src)
      SRC_NMI: return 8'h10;
      SRC_EXT: return {4'h2, line};
      SRC_ENC: return {4'h4, level};
      default: return {4'h8, level};
    endcase
  endfunction

endpackage

// File: rtl/irq_hold_qual.sv
module irq_hold_qual #(
  parameter int unsigned LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ready
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  assign ready = (cnt == CW'(LAT));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!req)   cnt <= '0;
    else if (!ready) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_EXT = 4
) (
  input  logic               nmi_rdy,
  input  logic [NUM_EXT-1:0] ext_rdy,
  input  logic               enc_rdy,
  input  logic [3:0]         enc_level,
  input  logic               per_rdy,
  input  logic [3:0]         per_level,
  input  logic [3:0]         sr_imask,
  output win_t               win
);
  logic       ext_hit;
  logic [3:0] ext_lvl;
  logic [3:0] ext_idx;

  always_comb begin
    ext_hit = 1'b0;
    ext_lvl = '0;
    ext_idx = '0;
    for (int k = NUM_EXT - 1; k >= 0; k--) begin
      if (ext_rdy[k]) begin
        ext_hit = 1'b1;
        ext_lvl = ext_line_level(k);
        ext_idx = 4'(k);
      end
    end
  end

  always_comb begin
    win = '0;
    if (per_rdy && per_level > sr_imask)
      win = '{valid: 1'b1, src: SRC_PER, level: per_level, line: 4'd0};
    if (enc_rdy && enc_level > sr_imask && (!win.valid || enc_level >= win.level))
      win = '{valid: 1'b1, src: SRC_ENC, level: enc_level, line: 4'd0};
    if (ext_hit && ext_lvl > sr_imask && (!win.valid || ext_lvl >= win.level))
      win = '{valid: 1'b1, src: SRC_EXT, level: ext_lvl, line: ext_idx};
    if (nmi_rdy)
      win = '{valid: 1'b1, src: SRC_NMI, level: 4'd15, line: 4'd0};
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int unsigned ENTRY = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  win_t       win,
  output logic       idle,
  output logic       save_sr_pc,
  output logic [3:0] save_imask,
  output logic       fetch_redirect,
  output logic [7:0] vector_code
);
  localparam int unsigned LAST = ENTRY + 1;
  localparam int unsigned PW   = $clog2(LAST + 1);

  logic [PW-1:0] ph;

  assign idle           = (ph == '0);
  assign save_sr_pc     = (ph == PW'(1));
  assign fetch_redirect = (ph == PW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= '0;
      save_imask  <= '0;
      vector_code <= '0;
    end else if (idle) begin
      if (take) begin
        ph          <= PW'(1);
        save_imask  <= win.level;
        vector_code <= vec_of(win.src, win.level, win.line);
      end
    end else begin
      ph <= (ph == PW'(LAST)) ? '0 : ph + 1'b1;
    end
  end

  // Independent distance counter from the save pulse
  logic [PW-1:0] since_save;
  always_ff @(posedge clk) begin
    if (!rst_n)                since_save <= '0;
    else if (save_sr_pc)       since_save <= PW'(1);
    else if (since_save != '0) since_save <= (since_save == PW'(ENTRY)) ? '0 : since_save + 1'b1;
  end

  // R7
  save_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_sr_pc |=> !save_sr_pc);
  // R8
  redirect_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |-> since_save == PW'(ENTRY));
  // R8
  redirect_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    since_save == PW'(ENTRY) |-> fetch_redirect);
  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_sr_pc, fetch_redirect}));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_EXT = 4,
  parameter int unsigned LAT_NMI = 3,
  parameter int unsigned LAT_EXT = 5,
  parameter int unsigned LAT_ENC = 4,
  parameter int unsigned LAT_PER = 4,
  parameter int unsigned ENTRY   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_done,
  input  logic               instr_clears_bl,
  input  logic               instr_sets_bl,
  input  logic               sr_bl,
  input  logic [3:0]         sr_imask,
  input  logic               nmi,
  input  logic [NUM_EXT-1:0] irq,
  input  logic [3:0]         irl_level,
  input  logic               periph_req,
  input  logic [3:0]         periph_level,
  output logic               save_sr_pc,
  output logic [3:0]         save_imask,
  output logic               fetch_redirect,
  output logic [7:0]         vector_code
);
  logic               nmi_rdy, enc_rdy, per_rdy;
  logic [NUM_EXT-1:0] ext_rdy;
  win_t               win;
  logic               idle;
  logic               blk_eff;
  logic               take;

  irq_hold_qual #(.LAT(LAT_NMI)) u_q_nmi (
    .clk(clk), .rst_n(rst_n), .req(nmi), .ready(nmi_rdy));
  irq_hold_qual #(.LAT(LAT_ENC)) u_q_enc (
    .clk(clk), .rst_n(rst_n), .req(irl_level != 4'd0), .ready(enc_rdy));
  irq_hold_qual #(.LAT(LAT_PER)) u_q_per (
    .clk(clk), .rst_n(rst_n), .req(periph_req), .ready(per_rdy));

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    irq_hold_qual #(.LAT(LAT_EXT)) u_q_ext (
      .clk(clk), .rst_n(rst_n), .req(irq[k]), .ready(ext_rdy[k]));
  end

  irq_arbiter #(.NUM_EXT(NUM_EXT)) u_arb (
    .nmi_rdy(nmi_rdy), .ext_rdy(ext_rdy), .enc_rdy(enc_rdy), .enc_level(irl_level),
    .per_rdy(per_rdy), .per_level(periph_level & {4{periph_req}}), .sr_imask(sr_imask),
    .win(win));

  // Block bit as it stands once the finishing instruction has retired
  assign blk_eff = instr_sets_bl ? 1'b1 : (instr_clears_bl ? 1'b0 : sr_bl);
  assign take    = instr_done && !blk_eff && win.valid;

  irq_entry_fsm #(.ENTRY(ENTRY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .win(win), .idle(idle),
    .save_sr_pc(save_sr_pc), .save_imask(save_imask),
    .fetch_redirect(fetch_redirect), .vector_code(vector_code));

  // R3
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_sr_pc |-> $past(instr_done));
  // R4
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_sr_pc |-> !$past(instr_sets_bl) && ($past(instr_clears_bl) || !$past(sr_bl)));
  // R5
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_sr_pc && vector_code != 8'h10 |-> save_imask > $past(sr_imask));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && !save_sr_pc |-> $stable(vector_code) && $stable(save_imask));
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_done = 1'b0, instr_clears_bl = 1'b0, instr_sets_bl = 1'b0, sr_bl = 1'b0;
  logic [3:0] sr_imask = '0;
  logic       nmi = 1'b0;
  logic [3:0] irq = '0;
  logic [3:0] irl_level = '0;
  logic       periph_req = 1'b0;
  logic [3:0] periph_level = '0;
  logic       save_sr_pc, fetch_redirect;
  logic [3:0] save_imask;
  logic [7:0] vector_code;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  localparam int L_NMI = 3, L_EXT = 5, L_ENC = 4, L_PER = 4;

  always #2 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .instr_clears_bl(instr_clears_bl),
    .instr_sets_bl(instr_sets_bl), .sr_bl(sr_bl), .sr_imask(sr_imask), .nmi(nmi),
    .irq(irq), .irl_level(irl_level), .periph_req(periph_req), .periph_level(periph_level),
    .save_sr_pc(save_sr_pc), .save_imask(save_imask), .fetch_redirect(fetch_redirect),
    .vector_code(vector_code));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    nmi = 0; irq = '0; irl_level = '0; periph_req = 0; periph_level = '0;
    instr_done = 0; instr_clears_bl = 0; instr_sets_bl = 0; sr_bl = 0; sr_imask = '0;
    repeat (8) step();
  endtask

  // Save expected after the next edge, redirect five cycles later
  task automatic expect_entry(input string req, input int vec, input int lvl);
    bit bad = 0;
    step();
    chk(save_sr_pc == 1'b1, {req, " save"}, save_sr_pc, 1);
    chk(save_imask == 4'(lvl), {req, " R7 imask"}, save_imask, lvl);
    for (int i = 0; i < 4; i++) begin
      step();
      if (save_sr_pc || fetch_redirect) bad = 1;
    end
    chk(!bad, {req, " R8 quiet gap"}, bad, 0);
    step();
    chk(fetch_redirect == 1'b1, {req, " R8 redirect"}, fetch_redirect, 1);
    chk(vector_code == 8'(vec), {req, " R9 vector"}, vector_code, vec);
    clear_all();
  endtask

  task automatic expect_none(input string req);
    bit seen = 0;
    repeat (4) begin
      step();
      if (save_sr_pc) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  // Boundary held open; request driven just before this call
  task automatic lat_case(input string req, input int lat, input int vec, input int lvl);
    int n = 0;
    for (int i = 1; i <= 20 && n == 0; i++) begin
      step();
      if (save_sr_pc) n = i;
    end
    chk(n == lat + 1, {req, " R2 latency"}, n, lat + 1);
    chk(save_imask == 4'(lvl), {req, " R7 imask"}, save_imask, lvl);
    repeat (5) step();
    chk(fetch_redirect == 1'b1, {req, " R8 redirect"}, fetch_redirect, 1);
    chk(vector_code == 8'(vec), {req, " R9 vector"}, vector_code, vec);
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk(!save_sr_pc && !fetch_redirect && vector_code == 0 && save_imask == 0,
        "R1 reset", {save_sr_pc, fetch_redirect}, 0);
    step(); step();
    rst_n = 1;
    clear_all();
    chk(!save_sr_pc && !fetch_redirect, "R1 idle after reset", save_sr_pc, 0);

    // R2 latency per class
    instr_done = 1; nmi = 1; sr_imask = 4'd15;
    lat_case("R2 nmi (R5 mask bypass)", L_NMI, 8'h10, 15);
    for (int k = 0; k < 4; k++) begin
      instr_done = 1; irq = 4'(1 << k);
      lat_case("R2 ext", L_EXT, 8'h20 + k, 15 - 2 * k);
    end
    instr_done = 1; irl_level = 4'd7;
    lat_case("R2 enc", L_ENC, 8'h47, 7);
    instr_done = 1; periph_req = 1; periph_level = 4'd9;
    lat_case("R2 per", L_PER, 8'h89, 9);

    // R5 mask sweeps
    for (int m = 0; m < 16; m++) begin
      for (int l = 1; l < 16; l++) begin
        sr_imask = 4'(m); irl_level = 4'(l);
        repeat (6) step();
        instr_done = 1;
        if (l > m) expect_entry("R5 enc", 8'h40 + l, l);
        else begin expect_none("R5 enc masked"); clear_all(); end
        sr_imask = 4'(m); periph_req = 1; periph_level = 4'(l);
        repeat (6) step();
        instr_done = 1;
        if (l > m) expect_entry("R5 per", 8'h80 + l, l);
        else begin expect_none("R5 per masked"); clear_all(); end
      end
    end
    for (int k = 0; k < 4; k++) begin
      sr_imask = 4'(15 - 2 * k); irq = 4'(1 << k);
      repeat (7) step();
      instr_done = 1;
      expect_none("R5 ext level equal to mask");
      clear_all();
      sr_imask = 4'(14 - 2 * k); irq = 4'(1 << k);
      repeat (7) step();
      instr_done = 1;
      expect_entry("R5 ext above mask", 8'h20 + k, 15 - 2 * k);
    end

    // R3 boundary
    irl_level = 4'd5;
    repeat (12) step();
    chk(!save_sr_pc, "R3 no boundary", save_sr_pc, 0);
    instr_done = 1;
    expect_entry("R3 boundary opens", 8'h45, 5);

    // R4 block bit
    sr_bl = 1; nmi = 1; instr_done = 1;
    repeat (5) step();
    expect_none("R4 blocked nmi");
    instr_clears_bl = 1;
    expect_entry("R4 clearing instruction", 8'h10, 15);
    nmi = 1; instr_done = 1; instr_sets_bl = 1;
    repeat (5) step();
    expect_none("R4 instruction sets block");
    sr_bl = 1; instr_clears_bl = 1;
    expect_none("R4 set wins over clear");
    clear_all();

    // R6 arbitration, all decided before the boundary opens
    irq = 4'b0100; irl_level = 4'd11;
    repeat (8) step(); instr_done = 1;
    expect_entry("R6 ext over enc tie", 8'h22, 11);
    irl_level = 4'd9; periph_req = 1; periph_level = 4'd9;
    repeat (8) step(); instr_done = 1;
    expect_entry("R6 enc over per tie", 8'h49, 9);
    irq = 4'b1000; irl_level = 4'd12; periph_req = 1; periph_level = 4'd13;
    repeat (8) step(); instr_done = 1;
    expect_entry("R6 highest level per", 8'h8D, 13);
    irq = 4'b0011; irl_level = 4'd15; periph_req = 1; periph_level = 4'd15;
    repeat (8) step(); instr_done = 1;
    expect_entry("R6 ext line0 wins", 8'h20, 15);
    nmi = 1; irq = 4'b1111; irl_level = 4'd15; periph_req = 1; periph_level = 4'd15;
    repeat (8) step(); instr_done = 1;
    expect_entry("R6 nmi first", 8'h10, 15);

    // R10 held request during entry
    begin
      int n = 0;
      bit dup = 0;
      nmi = 1; instr_done = 1;
      for (int i = 1; i <= 10 && n == 0; i++) begin
        step();
        if (save_sr_pc) n = i;
      end
      for (int i = 0; i < 4; i++) begin
        step();
        if (save_sr_pc) dup = 1;
      end
      step();
      chk(fetch_redirect && !save_sr_pc && !dup, "R10 no retake during entry", dup, 0);
      step();
      chk(!save_sr_pc, "R10 not retaken one after redirect", save_sr_pc, 0);
      step();
      chk(save_sr_pc == 1'b1, "R10 retaken two after redirect", save_sr_pc, 1);
      repeat (6) step();
      clear_all();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule